// File: doc/BRIEF.md
# Clear-on-read counter field

This block is one counter field of a memory-mapped register file. Software can only read it. Every bus read returns the value the counter holds at that moment and clears the counter as a side effect, so no write is needed to clear it. Bus writes to the same address leave the field untouched, which lets a write-only register share that address.

Hardware changes the counter through four strobes: step up, step down, clear, and return to the reset state. An optional write port can also change it. Depending on a parameter, that port loads a data word, adds it to the counter, or subtracts it. The counter wraps modulo 2^WIDTH in both directions. An optional strobe flags each upward wrap. An optional hardware copy of the count lets logic next to the field see the value without a bus access. A valid flag is set by reset and is not touched by clears or reads.

When several updates land in the same cycle, they are applied in a fixed order. A hardware reset wins over everything else. Next comes the clear, caused either by a bus read or by the clear strobe. The write port is then applied to the result, and finally the net step (+1, 0 or -1) of the two count strobes.

Top module: `cor_counter_field`

## Requirements
- R1: After the asynchronous reset (rst_n low), the count equals the parameter RESET_VALUE, field_valid is 1 and ovf_pulse is 0. field_valid stays 1 from then on.
- R2: While bus_rd_stb is high, bus_rd_data shows the count held before this cycle's update. While bus_rd_stb is low, bus_rd_data is all zeros.
- R3: A bus read clears the count at the next clock edge. The write port and the step strobes of the same cycle are then applied on top of zero, so a read together with hw_inc leaves the count at 1.
- R4: bus_wr_stb has no effect on the count, the overflow strobe or the valid flag.
- R5: hw_clear zeroes the count at the next edge and leaves field_valid unchanged. The write port and the step strobes of the same cycle are applied after the clear.
- R6: hw_reset returns the count to RESET_VALUE and sets field_valid at the next edge. It overrides every other input in that cycle.
- R7: hw_inc alone adds 1 and hw_dec alone subtracts 1, both modulo 2^WIDTH. Both strobes together leave the count unchanged.
- R8: With hw_we high, the write port acts before the step strobes. WR_MODE=WR_LOAD replaces the value with hw_wdata. WR_ACCUM adds hw_wdata, and WR_SUB subtracts it, both modulo 2^WIDTH. WR_OFF ignores the port.
- R9: When HAS_OVF=1, ovf_pulse is high for exactly the one cycle after an edge at which an add (write port) or net +1 step took the count's most significant bit from 1 to 0. Loads, subtracts and net -1 steps never raise it. When HAS_OVF=0 it stays 0.
- R10: When HW_READ=1, hw_value always equals the current count. When HW_READ=0, hw_value is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd_stb | input | 1 | Bus read of the field (destructive) |
| bus_wr_stb | input | 1 | Bus write to the shared address (ignored) |
| bus_rd_data | output | WIDTH | Read data, zero when not read |
| hw_reset | input | 1 | Return the field to its reset state |
| hw_clear | input | 1 | Zero the count |
| hw_inc | input | 1 | Step the count up by one |
| hw_dec | input | 1 | Step the count down by one |
| hw_we | input | 1 | Write-port enable |
| hw_wdata | input | WIDTH | Write-port data word |
| hw_value | output | WIDTH | Hardware copy of the count |
| field_valid | output | 1 | Valid flag |
| ovf_pulse | output | 1 | One-cycle upward wrap strobe |

## Verification
A wrong count shows up on hw_value at the very next clock edge, and on bus_rd_data in the same cycle as the following read. Because each read clears the count, a single bad update cannot carry over into later reads; it shows up once, on the read that follows it. A wrong order of priority among simultaneous updates shows up as a count that is off by the discarded or doubled contribution, so the bench drives every pairing of reset, read, clear, write port and steps. A missed or spurious wrap shows up on ovf_pulse one cycle after the edge that caused it.

// File: rtl/cor_counter_pkg.sv
package cor_counter_pkg;

   // Behaviour of the optional hardware write port
   typedef enum logic [1:0] {
      WR_OFF   = 2'd0,
      WR_LOAD  = 2'd1,
      WR_ACCUM = 2'd2,
      WR_SUB   = 2'd3
   } cor_wr_mode_e;

endpackage

// File: rtl/cor_write_stage.sv
module cor_write_stage
   import cor_counter_pkg::*;
#(
   parameter int           WIDTH = 16,
   parameter cor_wr_mode_e MODE  = WR_ACCUM
) (
   input  logic [WIDTH-1:0] base_i,
   input  logic             we_i,
   input  logic [WIDTH-1:0] data_i,
   output logic [WIDTH-1:0] result_o,
   output logic             up_wrap_o
);

   localparam int MSB = WIDTH - 1;

   generate
      if (MODE == WR_LOAD) begin : g_load
         assign result_o  = we_i ? data_i : base_i;
         assign up_wrap_o = 1'b0;
      end else if (MODE == WR_ACCUM) begin : g_accum
         logic [WIDTH-1:0] sum;
         assign sum       = base_i + data_i;
         assign result_o  = we_i ? sum : base_i;
         // upward wrap: top bit falls during an add
         assign up_wrap_o = we_i & base_i[MSB] & ~sum[MSB];
      end else if (MODE == WR_SUB) begin : g_sub
         assign result_o  = we_i ? (base_i - data_i) : base_i;
         assign up_wrap_o = 1'b0;
      end else begin : g_off
         logic unused_port;
         assign unused_port = we_i ^ (^data_i);
         assign result_o    = base_i;
         assign up_wrap_o   = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/cor_step_stage.sv
module cor_step_stage #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] base_i,
   input  logic             inc_i,
   input  logic             dec_i,
   output logic [WIDTH-1:0] result_o,
   output logic             up_wrap_o
);

   localparam int             MSB = WIDTH - 1;
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   logic [WIDTH-1:0] up_val;
   logic [WIDTH-1:0] dn_val;

   assign up_val = base_i + ONE;
   assign dn_val = base_i - ONE;

   always_comb begin
      result_o  = base_i;
      up_wrap_o = 1'b0;
      unique case ({inc_i, dec_i})
         2'b10: begin
            result_o  = up_val;
            up_wrap_o = base_i[MSB] & ~up_val[MSB];
         end
         2'b01: result_o = dn_val;
         default: result_o = base_i;
      endcase
   end

endmodule

// File: rtl/cor_counter_field.sv
module cor_counter_field
   import cor_counter_pkg::*;
#(
   parameter int           WIDTH       = 16,
   parameter int           RESET_VALUE = 0,
   parameter cor_wr_mode_e WR_MODE     = WR_ACCUM,
   parameter bit           HW_READ     = 1'b1,
   parameter bit           HAS_OVF     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rd_stb,
   input  logic             bus_wr_stb,
   output logic [WIDTH-1:0] bus_rd_data,
   input  logic             hw_reset,
   input  logic             hw_clear,
   input  logic             hw_inc,
   input  logic             hw_dec,
   input  logic             hw_we,
   input  logic [WIDTH-1:0] hw_wdata,
   output logic [WIDTH-1:0] hw_value,
   output logic             field_valid,
   output logic             ovf_pulse
);

   localparam logic [WIDTH-1:0] RST_WORD = WIDTH'(RESET_VALUE);
   localparam logic [WIDTH-1:0] ZERO     = '0;

   // elaboration-time parameter checks
   generate
      if (WIDTH < 2 || WIDTH > 32) begin : g_bad_width
         $error("cor_counter_field: WIDTH must lie in 2..32");
      end
      if (RESET_VALUE < 0 || longint'(RESET_VALUE) >= (64'sd1 <<< WIDTH)) begin : g_bad_rst
         $error("cor_counter_field: RESET_VALUE does not fit in WIDTH bits");
      end
   endgenerate

   logic [WIDTH-1:0] count_q;
   logic             valid_q;
   logic [WIDTH-1:0] base_val;
   logic [WIDTH-1:0] wr_val;
   logic [WIDTH-1:0] step_val;
   logic [WIDTH-1:0] next_val;
   logic             wr_wrap;
   logic             step_wrap;
   logic             wrap_any;
   logic             unused_bus_wr;

   // bus writes share the address but never reach this field
   assign unused_bus_wr = bus_wr_stb;

   // clear stage: a destructive read and the clear strobe both start from zero
   assign base_val = (bus_rd_stb | hw_clear) ? ZERO : count_q;

   cor_write_stage #(
      .WIDTH (WIDTH),
      .MODE  (WR_MODE)
   ) u_wr (
      .base_i    (base_val),
      .we_i      (hw_we),
      .data_i    (hw_wdata),
      .result_o  (wr_val),
      .up_wrap_o (wr_wrap)
   );

   cor_step_stage #(
      .WIDTH (WIDTH)
   ) u_step (
      .base_i    (wr_val),
      .inc_i     (hw_inc),
      .dec_i     (hw_dec),
      .result_o  (step_val),
      .up_wrap_o (step_wrap)
   );

   always_comb begin
      if (hw_reset) begin
         next_val = RST_WORD;
         wrap_any = 1'b0;
      end else begin
         next_val = step_val;
         wrap_any = wr_wrap | step_wrap;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= RST_WORD;
         valid_q <= 1'b1;
      end else begin
         count_q <= next_val;
         if (hw_reset) begin
            valid_q <= 1'b1;
         end
      end
   end

   assign bus_rd_data = bus_rd_stb ? count_q : ZERO;
   assign field_valid = valid_q;

   generate
      if (HW_READ) begin : g_hw_rd
         assign hw_value = count_q;
      end else begin : g_no_hw_rd
         assign hw_value = ZERO;
      end

      if (HAS_OVF) begin : g_ovf
         logic ovf_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ovf_q <= 1'b0;
            end else begin
               ovf_q <= wrap_any;
            end
         end
         assign ovf_pulse = ovf_q;
      end else begin : g_no_ovf
         logic unused_wrap;
         assign unused_wrap = wrap_any;
         assign ovf_pulse   = 1'b0;
      end
   endgenerate

   // ---------------------------------------------------------------
   // properties
   // ---------------------------------------------------------------
   logic quiet_hw;
   assign quiet_hw = !hw_reset && !hw_we && !hw_clear;

   p_valid_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      field_valid);

   p_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_stb && quiet_hw && !hw_inc && !hw_dec |=> count_q == ZERO);

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_stb && quiet_hw && !hw_inc && !hw_dec |=> $stable(count_q));

   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hw_clear && !hw_reset && !hw_we && !hw_inc && !hw_dec |=> count_q == ZERO);

   p_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hw_reset |=> count_q == RST_WORD && field_valid && !ovf_pulse);

   p_step_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hw_inc && !hw_dec && quiet_hw && !bus_rd_stb
      |=> count_q == $past(count_q) + WIDTH'(1));

   p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hw_inc && hw_dec && quiet_hw && !bus_rd_stb |=> $stable(count_q));

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hw_dec && !hw_inc && !hw_we |=> !ovf_pulse);

endmodule

// File: tb/cor_counter_field_tb.sv
`timescale 1ns/1ps
module cor_counter_field_tb;
   import cor_counter_pkg::*;

   localparam int W  = 8;
   localparam int RV = 5;
   localparam int M  = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd = 0, wr = 0, rs = 0, cl = 0, inc = 0, dec = 0, we = 0;
   logic [W-1:0] wd = '0;

   logic [W-1:0] rdata [3];
   logic [W-1:0] hval  [3];
   logic         vld   [3];
   logic         ovf   [3];

   int checks = 0;
   int fails  = 0;
   int model_cnt [3];

   always #4 clk = ~clk;

   cor_counter_field #(.WIDTH(W), .RESET_VALUE(RV), .WR_MODE(WR_ACCUM),
                       .HW_READ(1'b1), .HAS_OVF(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_rd_stb(rd), .bus_wr_stb(wr),
      .bus_rd_data(rdata[0]), .hw_reset(rs), .hw_clear(cl), .hw_inc(inc),
      .hw_dec(dec), .hw_we(we), .hw_wdata(wd), .hw_value(hval[0]),
      .field_valid(vld[0]), .ovf_pulse(ovf[0]));

   cor_counter_field #(.WIDTH(W), .RESET_VALUE(RV), .WR_MODE(WR_LOAD),
                       .HW_READ(1'b1), .HAS_OVF(1'b1)) u_dut_ld (
      .clk(clk), .rst_n(rst_n), .bus_rd_stb(rd), .bus_wr_stb(wr),
      .bus_rd_data(rdata[1]), .hw_reset(rs), .hw_clear(cl), .hw_inc(inc),
      .hw_dec(dec), .hw_we(we), .hw_wdata(wd), .hw_value(hval[1]),
      .field_valid(vld[1]), .ovf_pulse(ovf[1]));

   cor_counter_field #(.WIDTH(W), .RESET_VALUE(RV), .WR_MODE(WR_SUB),
                       .HW_READ(1'b1), .HAS_OVF(1'b0)) u_dut_sb (
      .clk(clk), .rst_n(rst_n), .bus_rd_stb(rd), .bus_wr_stb(wr),
      .bus_rd_data(rdata[2]), .hw_reset(rs), .hw_clear(cl), .hw_inc(inc),
      .hw_dec(dec), .hw_we(we), .hw_wdata(wd), .hw_value(hval[2]),
      .field_valid(vld[2]), .ovf_pulse(ovf[2]));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // reference: mode 0 = accumulate, 1 = load, 2 = subtract (no overflow output)
   function automatic void model(input int c, input int mode, output int n, output bit ov);
      int b;
      int r;
      ov = 0;
      if (rs) begin n = RV; return; end          // R6
      b = (rd || cl) ? 0 : c;                     // R3, R5
      if (we) begin                               // R8
         if (mode == 0) begin
            r = (b + int'(wd)) % M;
            if (b >= M/2 && r < M/2) ov = 1;
            b = r;
         end else if (mode == 1) begin
            b = int'(wd);
         end else begin
            b = (b - int'(wd) + M) % M;
         end
      end
      if (inc && !dec) begin                      // R7
         r = (b + 1) % M;
         if (b >= M/2 && r < M/2) ov = 1;
         b = r;
      end else if (dec && !inc) begin
         b = (b + M - 1) % M;
      end
      if (mode == 2) ov = 0;
      n = b;
   endfunction

   task automatic step(input bit i_rd, i_wr, i_rs, i_cl, i_inc, i_dec, i_we,
                       input int i_wd, input string tag);
      bit exp_ov [3];
      int nx;
      rd = i_rd; wr = i_wr; rs = i_rs; cl = i_cl; inc = i_inc; dec = i_dec;
      we = i_we; wd = W'(i_wd);
      #1;
      for (int k = 0; k < 3; k++) begin
         int e;
         e = rd ? model_cnt[k] : 0;
         chk(int'(rdata[k]) == e, {"R2 ", tag}, int'(rdata[k]), e);
      end
      @(posedge clk);
      for (int k = 0; k < 3; k++) begin
         model(model_cnt[k], k, nx, exp_ov[k]);
         model_cnt[k] = nx;
      end
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
         chk(int'(hval[k]) == model_cnt[k], {"R10 count ", tag}, int'(hval[k]), model_cnt[k]);
         chk(ovf[k] == exp_ov[k], {"R9 ", tag}, int'(ovf[k]), int'(exp_ov[k]));
         chk(vld[k] == 1'b1, {"R1 valid ", tag}, int'(vld[k]), 1);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int k = 0; k < 3; k++) model_cnt[k] = RV;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      for (int k = 0; k < 3; k++) begin
         chk(int'(hval[k]) == RV, "R1 reset count", int'(hval[k]), RV);
         chk(vld[k] == 1'b1, "R1 reset valid", int'(vld[k]), 1);
         chk(ovf[k] == 1'b0, "R1 reset ovf", int'(ovf[k]), 0);
      end
      //   rd wr rs cl in de we wd
      step(0, 1, 0, 0, 0, 0, 0, 77, "R4 bus write ignored");
      step(0, 1, 0, 0, 0, 0, 0, 0,  "R4 bus write ignored again");
      step(0, 0, 0, 0, 1, 0, 0, 0,  "R7 inc");
      step(0, 0, 0, 0, 1, 0, 0, 0,  "R7 inc");
      step(1, 0, 0, 0, 0, 0, 0, 0,  "R3 read clears");
      step(0, 0, 0, 0, 1, 0, 0, 0,  "R7 inc");
      step(1, 0, 0, 0, 1, 0, 0, 0,  "R3 read with inc ends at 1");
      step(0, 0, 0, 0, 0, 1, 0, 0,  "R7 dec");
      step(0, 0, 0, 0, 0, 1, 0, 0,  "R7 dec wraps below zero");
      step(0, 0, 0, 0, 1, 1, 0, 0,  "R7 inc and dec cancel");
      step(0, 0, 0, 0, 1, 0, 0, 0,  "R9 inc wraps 255 to 0");
      step(0, 0, 0, 0, 0, 0, 1, 200, "R8 write port");
      step(0, 0, 0, 0, 0, 0, 1, 100, "R8 add wraps");
      step(0, 0, 0, 0, 1, 0, 1, 127, "R8 write then inc");
      step(0, 0, 0, 1, 1, 0, 0, 0,  "R5 clear then inc");
      step(0, 0, 0, 1, 0, 0, 1, 9,  "R5 clear then write");
      step(1, 0, 0, 0, 0, 0, 1, 33, "R3 read then write");
      step(1, 0, 1, 1, 1, 0, 1, 50, "R6 reset overrides all");
      step(0, 0, 0, 1, 0, 0, 0, 0,  "R5 clear keeps valid");
      step(0, 0, 0, 0, 0, 1, 1, 3,  "R8 write then dec");
      step(0, 0, 0, 0, 0, 0, 1, 128, "R8 write 128");
      step(0, 0, 0, 0, 1, 0, 0, 0,  "R9 inc");
      for (int n = 0; n < 400; n++) begin
         step(($urandom % 3) == 0, $urandom % 2, ($urandom % 16) == 0,
              ($urandom % 8) == 0, $urandom % 2, $urandom % 2,
              $urandom % 2, int'($urandom % M), "R3 R8 random mix");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule